// File: doc/BRIEF.md
# Multicycle Long Integer Divider

This block divides a 32-bit or 64-bit dividend by a 32-bit divisor, signed or unsigned, one quotient bit per clock. A control word chooses the mode. Its signedness bit and its width bit are the only fields the block decodes. The caller presents two register values, `hi_val` and `lo_val`, and the divisor, then pulses `start`. When the operation completes, the block pulses `done`. In that same cycle it reports the quotient, the remainder, four condition flags, a write strobe and a divide-by-zero indication.

Inside, the block makes the operands non-negative, runs a fixed 32-step restoring loop on the magnitudes and then corrects the signs. An operation whose quotient does not fit in 32 bits is reported as an overflow and produces no write. So is a zero divisor. In both cases the quotient and remainder outputs keep the values of the last successful division. The caller uses `wr_en` to decide whether to update its registers, and `div_zero` to raise its own trap.

Top module: `wide_div_core`

## Requirements
- R1: Control bit 11 set selects signed operation, and control bit 10 set selects a 64-bit dividend {hi_val, lo_val}. With bit 10 clear, `hi_val` is ignored: the dividend is `lo_val`, zero-extended when unsigned and sign-extended when signed.
- R2: A zero divisor completes with `div_zero`=1, `wr_en`=0 and all four flags 0. The quotient and remainder outputs keep their previous values.
- R3: A successful unsigned division gives the exact quotient and remainder, with `wr_en`=1, V=0, C=0, Z=(quotient==0) and N=quotient bit 31.
- R4: An unsigned division whose quotient needs more than 32 bits (divisor ≤ the dividend's high word) completes with V=1, N=1, Z=0, C=0 and `wr_en`=0, and the quotient and remainder outputs hold.
- R5: A signed division truncates toward zero. The quotient is negative when the operand signs differ, and a non-zero remainder carries the sign of the dividend. The flags follow the rule of R3.
- R6: A signed quotient magnitude above 0x80000000 for a negative result, or above 0x7FFFFFFF for a positive result, is an overflow reported as in R4.
- R7: `busy` rises on the edge that samples `start` and stays high for 34 cycles. `done` pulses for one cycle on the 34th rising edge after the sampling edge, and `busy` is low in that cycle.
- R8: `start` is ignored while `busy` is high. The running result is unaffected, and no further operation begins.
- R9: `wr_en` and `div_zero` are high only in the `done` cycle. The quotient, remainder and flags change only on a completion.
- R10: After reset, all outputs are 0.
- R11: The C flag is 0 after every completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| ctl_word | input | 16 | Control word: bit 11 signed, bit 10 64-bit dividend |
| hi_val | input | 32 | High dividend word, used only in 64-bit mode |
| lo_val | input | 32 | Low dividend word |
| dvs_val | input | 32 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Last successfully written quotient |
| remainder | output | 32 | Last successfully written remainder |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (always cleared) |
| div_zero | output | 1 | Zero divisor indication, with done |
| wr_en | output | 1 | Result write strobe, with done |

## Verification
The loop has no intermediate visibility. A wrong shift, a lost carry bit or a miscounted step therefore appears only at completion, 34 cycles after start, as a wrong quotient or remainder, or as `done` arriving on the wrong cycle. Sign-correction faults show up only in the signed cases with mixed operand signs, and a wrong overflow bound shows up only at the exact quotient magnitudes 0x7FFFFFFF and 0x80000000. The directed cases therefore sit on those magnitudes, on both sign combinations and on the zero-divisor and ignored-start paths. Every completion is compared against an arithmetic model.

// File: rtl/wide_div_pkg.sv
package wide_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_ITER = 2'd2,
    ST_FIX  = 2'd3
  } div_state_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } div_flags_t;
endpackage

// File: rtl/wdiv_prep.sv
// Operand conditioning: dividend extension, magnitudes, sign bookkeeping
module wdiv_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] dvs_in,
  input  logic         sgn,
  input  logic         wide,
  output logic [W-1:0] mag_hi,
  output logic [W-1:0] mag_lo,
  output logic [W-1:0] dmag,
  output logic         quo_neg,
  output logic         dvd_neg,
  output logic         dz,
  output logic         early_ovf
);
  logic [W-1:0]   hi_ext;
  logic [2*W-1:0] cat;
  logic [2*W-1:0] cat_mag;

  always_comb begin
    if (wide)
      hi_ext = hi_in;
    else if (sgn)
      hi_ext = {W{lo_in[W-1]}};
    else
      hi_ext = '0;
    cat     = {hi_ext, lo_in};
    dvd_neg = sgn & hi_ext[W-1];
    cat_mag = dvd_neg ? -cat : cat;
    mag_hi  = cat_mag[2*W-1:W];
    mag_lo  = cat_mag[W-1:0];
    dmag    = (sgn & dvs_in[W-1]) ? -dvs_in : dvs_in;
    quo_neg = sgn & (hi_ext[W-1] ^ dvs_in[W-1]);
    dz      = (dvs_in == '0);
    // quotient cannot fit when the high word already reaches the divisor
    early_ovf = (dmag <= mag_hi);
  end
endmodule

// File: rtl/wdiv_step.sv
// One restoring step: shift pair left, keep the carry, conditional subtract
module wdiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] q_in,
  input  logic [W-1:0] dmag,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out,
  output logic [W-1:0] q_out
);
  logic [W-1:0] sh;
  logic         carry;
  logic         take;

  always_comb begin
    carry  = hi_in[W-1];
    sh     = {hi_in[W-2:0], lo_in[W-1]};
    take   = carry | (sh >= dmag);
    hi_out = take ? (sh - dmag) : sh;
    lo_out = {lo_in[W-2:0], 1'b0};
    q_out  = {q_in[W-2:0], take};
  end
endmodule

// File: rtl/wdiv_fix.sv
// Post-correction: sign restore, signed range check, flag formation
module wdiv_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0]             q_mag,
  input  logic [W-1:0]             r_mag,
  input  logic                     sgn,
  input  logic                     quo_neg,
  input  logic                     dvd_neg,
  input  logic                     dz,
  input  logic                     early_ovf,
  output logic [W-1:0]             quot,
  output logic [W-1:0]             rem,
  output wide_div_pkg::div_flags_t flags,
  output logic                     wr
);
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};

  logic q_over;
  logic bad;

  always_comb begin
    q_over = sgn & (q_mag > (quo_neg ? NEG_LIM : POS_LIM));
    bad    = early_ovf | q_over;
    quot   = quo_neg ? -q_mag : q_mag;
    rem    = dvd_neg ? -r_mag : r_mag;
    wr     = ~dz & ~bad;
    flags.c = 1'b0;
    if (dz) begin
      flags.n = 1'b0;
      flags.z = 1'b0;
      flags.v = 1'b0;
    end else if (bad) begin
      flags.n = 1'b1;
      flags.z = 1'b0;
      flags.v = 1'b1;
    end else begin
      flags.n = quot[W-1];
      flags.z = (quot == '0);
      flags.v = 1'b0;
    end
  end
endmodule

// File: rtl/wide_div_core.sv
module wide_div_core #(
  parameter int DATA_W   = 32,
  parameter int CTL_W    = 16,
  parameter int SIGN_POS = 11,
  parameter int WIDE_POS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic [DATA_W-1:0] hi_val,
  input  logic [DATA_W-1:0] lo_val,
  input  logic [DATA_W-1:0] dvs_val,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              div_zero,
  output logic              wr_en
);
  import wide_div_pkg::*;

  localparam int               CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

  div_state_t        state;
  logic [CNT_W-1:0]  step_cnt;
  logic [DATA_W-1:0] op_hi, op_lo, op_dvs;
  logic              op_sgn, op_wide;
  logic [DATA_W-1:0] acc_hi, acc_lo, acc_q, dmag_q;
  logic              quo_neg_q, dvd_neg_q, dz_q, eovf_q;

  logic [DATA_W-1:0] p_hi, p_lo, p_dmag;
  logic              p_qneg, p_dneg, p_dz, p_eovf;
  logic [DATA_W-1:0] s_hi, s_lo, s_q;
  logic [DATA_W-1:0] f_quot, f_rem;
  div_flags_t        f_flags;
  logic              f_wr;

  wdiv_prep #(.W(DATA_W)) prep_i (
    .hi_in(op_hi), .lo_in(op_lo), .dvs_in(op_dvs),
    .sgn(op_sgn), .wide(op_wide),
    .mag_hi(p_hi), .mag_lo(p_lo), .dmag(p_dmag),
    .quo_neg(p_qneg), .dvd_neg(p_dneg), .dz(p_dz), .early_ovf(p_eovf)
  );

  wdiv_step #(.W(DATA_W)) step_i (
    .hi_in(acc_hi), .lo_in(acc_lo), .q_in(acc_q), .dmag(dmag_q),
    .hi_out(s_hi), .lo_out(s_lo), .q_out(s_q)
  );

  wdiv_fix #(.W(DATA_W)) fix_i (
    .q_mag(acc_q), .r_mag(acc_hi), .sgn(op_sgn),
    .quo_neg(quo_neg_q), .dvd_neg(dvd_neg_q), .dz(dz_q), .early_ovf(eovf_q),
    .quot(f_quot), .rem(f_rem), .flags(f_flags), .wr(f_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step_cnt  <= '0;
      op_hi     <= '0;
      op_lo     <= '0;
      op_dvs    <= '0;
      op_sgn    <= 1'b0;
      op_wide   <= 1'b0;
      acc_hi    <= '0;
      acc_lo    <= '0;
      acc_q     <= '0;
      dmag_q    <= '0;
      quo_neg_q <= 1'b0;
      dvd_neg_q <= 1'b0;
      dz_q      <= 1'b0;
      eovf_q    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
      div_zero  <= 1'b0;
      wr_en     <= 1'b0;
    end else begin
      done     <= 1'b0;
      wr_en    <= 1'b0;
      div_zero <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            op_hi   <= hi_val;
            op_lo   <= lo_val;
            op_dvs  <= dvs_val;
            op_sgn  <= ctl_word[SIGN_POS];
            op_wide <= ctl_word[WIDE_POS];
            busy    <= 1'b1;
            state   <= ST_PREP;
          end
        end
        ST_PREP: begin
          acc_hi    <= p_hi;
          acc_lo    <= p_lo;
          acc_q     <= '0;
          dmag_q    <= p_dmag;
          quo_neg_q <= p_qneg;
          dvd_neg_q <= p_dneg;
          dz_q      <= p_dz;
          eovf_q    <= p_eovf;
          step_cnt  <= '0;
          state     <= ST_ITER;
        end
        ST_ITER: begin
          acc_hi   <= s_hi;
          acc_lo   <= s_lo;
          acc_q    <= s_q;
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST)
            state <= ST_FIX;
        end
        ST_FIX: begin
          done     <= 1'b1;
          busy     <= 1'b0;
          wr_en    <= f_wr;
          div_zero <= dz_q;
          flag_n   <= f_flags.n;
          flag_z   <= f_flags.z;
          flag_v   <= f_flags.v;
          flag_c   <= f_flags.c;
          if (f_wr) begin
            quotient  <= f_quot;
            remainder <= f_rem;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wide_div_core_chk.sv
module wide_div_core_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic         done,
  input logic         wr_en,
  input logic         div_zero,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_v,
  input logic         flag_c,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);
  localparam int RL_W = $clog2(W + 3) + 1;
  localparam logic [RL_W-1:0] RUN_LEN = RL_W'(W + 2);

  logic [RL_W-1:0] run_len;
  logic            busy_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      busy_d  <= 1'b0;
    end else begin
      busy_d <= busy;
      if (busy)
        run_len <= busy_d ? run_len + 1'b1 : RL_W'(1);
    end
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && run_len == RUN_LEN));

  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_len <= RUN_LEN);

  // R9
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> done);

  // R2
  dz_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    div_zero |-> (done && !wr_en && !flag_v && !flag_n && !flag_z));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (done && flag_v) |-> (flag_n && !flag_z && !wr_en));

  // R11
  carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !flag_c);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> ($stable(quotient) && $stable(remainder)));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (flag_z == (quotient == '0)));
endmodule

bind wide_div_core wide_div_core_chk #(.W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .wr_en(wr_en),
  .div_zero(div_zero), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
  .flag_c(flag_c), .quotient(quotient), .remainder(remainder)
);

// File: tb/wide_div_core_tb_top.sv
module wide_div_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] ctl_word = '0;
  logic [31:0] hi_val = '0, lo_val = '0, dvs_val = '0;
  logic        busy, done, flag_n, flag_z, flag_v, flag_c, div_zero, wr_en;
  logic [31:0] quotient, remainder;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] last_q = '0, last_r = '0;

  always #5 clk = ~clk;

  wide_div_core dut_i (
    .clk(clk), .rst(rst), .start(start), .ctl_word(ctl_word),
    .hi_val(hi_val), .lo_val(lo_val), .dvs_val(dvs_val),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .div_zero(div_zero), .wr_en(wr_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // arithmetic model of the requirements
  task automatic model(input bit sgn, input bit wide, input logic [31:0] hi,
                       input logic [31:0] lo, input logic [31:0] d,
                       output bit e_dz, output bit e_ovf,
                       output logic [31:0] e_q, output logic [31:0] e_r);
    logic [63:0] a, am, dm, qm, rm;
    bit an, neg;
    e_dz = (d == 0);
    e_ovf = 0;
    e_q = '0;
    e_r = '0;
    if (e_dz) return;
    if (!sgn) begin
      a  = wide ? {hi, lo} : {32'h0, lo};
      qm = a / {32'h0, d};
      rm = a % {32'h0, d};
      e_ovf = (qm[63:32] != 0);
      e_q = qm[31:0];
      e_r = rm[31:0];
    end else begin
      a   = wide ? {hi, lo} : {{32{lo[31]}}, lo};
      an  = a[63];
      am  = an ? -a : a;
      dm  = d[31] ? {32'h0, -d} : {32'h0, d};
      qm  = am / dm;
      rm  = am % dm;
      neg = an ^ d[31];
      e_ovf = neg ? (qm > 64'h8000_0000) : (qm > 64'h7FFF_FFFF);
      e_q = neg ? -qm[31:0] : qm[31:0];
      e_r = an ? -rm[31:0] : rm[31:0];
    end
  endtask

  // issue one operation; optionally pulse start again mid-run with junk operands
  task automatic run_case(input string name, input bit sgn, input bit wide,
                          input logic [31:0] hi, input logic [31:0] lo,
                          input logic [31:0] d, input bit restart);
    bit e_dz, e_ovf;
    logic [31:0] e_q, e_r;
    int n;
    model(sgn, wide, hi, lo, d, e_dz, e_ovf, e_q, e_r);
    @(negedge clk);
    ctl_word = 16'h7007 | (16'(sgn) << 11) | (16'(wide) << 10);
    hi_val = hi; lo_val = lo; dvs_val = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    hi_val = 32'hA5A5_A5A5; lo_val = 32'h5A5A_5A5A; dvs_val = 32'h3;
    chk({name, " R7 busy after start"}, 32'(busy), 32'd1);
    n = 1;
    while (!done && n < 100) begin
      if (restart && n == 5) start = 1'b1;
      if (restart && n == 6) start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk({name, " R7 latency"}, 32'(n - 1), 32'd34);
    chk({name, " R7 busy low at done"}, 32'(busy), 32'd0);
    chk({name, " R11 carry"}, 32'(flag_c), 32'd0);
    if (e_dz) begin
      chk({name, " R2 div_zero"}, 32'(div_zero), 32'd1);
      chk({name, " R2 no write"}, 32'(wr_en), 32'd0);
      chk({name, " R2 flags"}, {28'h0, flag_n, flag_z, flag_v, flag_c}, 32'h0);
      chk({name, " R2 quotient held"}, quotient, last_q);
      chk({name, " R2 remainder held"}, remainder, last_r);
    end else if (e_ovf) begin
      chk({name, " R4 R6 overflow flags"}, {28'h0, flag_n, flag_z, flag_v, flag_c}, 32'hA);
      chk({name, " R4 R6 no write"}, 32'(wr_en), 32'd0);
      chk({name, " R4 R6 quotient held"}, quotient, last_q);
      chk({name, " R4 R6 remainder held"}, remainder, last_r);
      chk({name, " R4 div_zero low"}, 32'(div_zero), 32'd0);
    end else begin
      chk({name, " R3 R5 write"}, 32'(wr_en), 32'd1);
      chk({name, " R3 R5 quotient"}, quotient, e_q);
      chk({name, " R3 R5 remainder"}, remainder, e_r);
      chk({name, " R3 R5 flags"}, {28'h0, flag_n, flag_z, flag_v, flag_c},
          {28'h0, e_q[31], (e_q == 0), 2'b00});
      last_q = e_q;
      last_r = e_r;
    end
    @(negedge clk);
    chk({name, " R9 done pulse"}, 32'(done), 32'd0);
    chk({name, " R9 wr_en pulse"}, 32'(wr_en), 32'd0);
    chk({name, " R8 no extra run"}, 32'(busy), 32'd0);
  endtask

  task automatic t_reset();
    chk("R10 reset outputs", {26'h0, busy, done, wr_en, div_zero, flag_v, flag_n}, 32'h0);
    chk("R10 reset quotient", quotient, 32'h0);
    chk("R10 reset remainder", remainder, 32'h0);
  endtask

  task automatic t_unsigned_narrow();
    run_case("unsigned 100/7 hi ignored R1", 0, 0, 32'hDEAD_BEEF, 32'd100, 32'd7, 0);
    run_case("unsigned 3/5 zero quotient", 0, 0, 32'h0, 32'd3, 32'd5, 0);
    run_case("unsigned max/1 N set", 0, 0, 32'h0, 32'hFFFF_FFFF, 32'd1, 0);
  endtask

  task automatic t_unsigned_wide();
    run_case("unsigned 64-bit R1", 0, 1, 32'd3, 32'h1234_5678, 32'h1000_0000, 0);
    run_case("unsigned overflow hi==d", 0, 1, 32'd5, 32'h0, 32'd5, 0);
  endtask

  task automatic t_zero_div();
    run_case("divide by zero", 1, 1, 32'h1, 32'h2, 32'h0, 0);
  endtask

  task automatic t_signed();
    run_case("signed -7/2", 1, 0, 32'hFFFF_0000, 32'hFFFF_FFF9, 32'd2, 0);
    run_case("signed 7/-2", 1, 0, 32'h0, 32'd7, 32'hFFFF_FFFE, 0);
    run_case("signed -100/-9", 1, 0, 32'h0, -32'd100, -32'd9, 0);
    run_case("signed 64 -2^31/1 edge", 1, 1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 0);
    run_case("signed 64 2^31-1 edge", 1, 1, 32'h0, 32'h7FFF_FFFF, 32'd1, 0);
  endtask

  task automatic t_signed_ovf();
    run_case("signed overflow -2^31/-1", 1, 0, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    run_case("signed overflow 2^31/1 wide", 1, 1, 32'h0, 32'h8000_0000, 32'd1, 0);
    run_case("signed overflow -2^63/-1", 1, 1, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_restart_ignored();
    run_case("R8 start while busy", 0, 0, 32'h0, 32'd1000, 32'd33, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unsigned_narrow();
    t_unsigned_wide();
    t_zero_div();
    t_signed();
    t_signed_ovf();
    t_restart_ignored();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule